// File: doc/BRIEF.md
# Receive Buffer Credit Tracker with Hysteretic Flow Control

This block keeps, for each receive channel of a DMA engine, a running count of the receive buffers that software has handed to the hardware. Software credits buffers by writing an increment to the channel's allocation register, or overwrites the count outright by setting a load flag in the same register. Each time the channel uses up a receive descriptor, it sends a one-cycle consume pulse, and the count drops by one.

Every channel has a programmable low and high threshold. Its pause request turns on once the count sinks below the low mark. It stays on until the count climbs back to the high mark or above. The gap between the two marks stops the request from chattering around a single level. After reset the marks sit at one third and two thirds of the ring depth. The request reaches the output only while the global enable is set and the enable bit shared by that channel's pair is set. Both bits live in a single configuration register.

Top module: `rx_fc_tracker`

## Requirements
- R1: After reset every count is 0, every pause request is low, the configuration register is 0, and the thresholds take their reset values: low = RING_DEPTH/3 (21) and high = 2*RING_DEPTH/3 (42).
- R2: A write to register kind 3 (allocation) with bit 31 clear adds the value in wr_data[CNT_W-1:0] to the count of the addressed channel. The new count appears at the edge that takes the write.
- R3: A write to register kind 3 with bit 31 set loads wr_data[CNT_W-1:0] into the count at that edge.
- R4: A consume pulse lowers its channel's count by one. At zero the count stays at zero and does not wrap.
- R5: If an increment and a consume pulse land in the same cycle, the count moves by the net amount. If a load and a consume pulse land together, the loaded value wins.
- R6: When an increment would push the count past 2^CNT_W-1, the count saturates at that maximum.
- R7: Register kind 1 sets the addressed channel's low threshold and kind 2 sets its high threshold, each from wr_data[CNT_W-1:0].
- R8: The per-channel request state becomes 1 one edge after the count is seen below the low threshold.
- R9: Once set, the request state holds while low <= count < high. It clears one edge after the count is seen at or above the high threshold.
- R10: fc_req[c] is the request state ANDed with configuration bit 0 (global enable) and configuration bit ((c>>1)+1) (enable for the channel pair). A change to the configuration shows on fc_req right after the edge that takes the write.
- R11: Channels are independent: a write or consume pulse addressed to one channel leaves every other channel's count and request unchanged.
- R12: wr_addr[1:0] selects the register kind (0 configuration, 1 low, 2 high, 3 allocation) and wr_addr[CH_W+1:2] selects the channel. A configuration write ignores the channel field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | CH_W+2 | Register kind in [1:0], channel in the upper bits |
| wr_data | input | 32 | Write data; bit 31 is the load flag for allocation writes |
| consume | input | NUM_CH | One-cycle descriptor-consumed pulse per channel |
| fc_req | output | NUM_CH | Gated pause request per channel |
| buf_count | output | NUM_CH*CNT_W | Current buffer counts, channel c in bits [c*CNT_W +: CNT_W] |

## Verification
A write or consume pulse changes the count at the same edge that takes it. The request state follows the count one edge later, because it compares the registered count. A configuration write reaches fc_req at the edge that takes it, with no added delay. The bench's reference model applies these same edge rules: at each rising edge it works out the next request state from the old count, and then the next count. It queues the expected count and request for every channel and compares them one time unit after the following falling edge. Each comparison therefore lands in the first cycle where the result is due.

// File: rtl/rx_fc_pkg.sv
package rx_fc_pkg;
  typedef enum logic [1:0] {
    KIND_CFG   = 2'd0,
    KIND_LOW   = 2'd1,
    KIND_HIGH  = 2'd2,
    KIND_ALLOC = 2'd3
  } fc_kind_e;

  localparam int LOAD_FLAG_BIT = 31;

  function automatic int pair_en_bit(input int ch);
    return (ch >> 1) + 1;
  endfunction
endpackage

// File: rtl/fc_reg_decode.sv
module fc_reg_decode
  import rx_fc_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CNT_W    = 8,
  parameter int CH_W     = 2,
  parameter int CFG_W    = 3,
  parameter int LOW_RST  = 21,
  parameter int HIGH_RST = 42
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CH_W+1:0]         wr_addr,
  input  logic [31:0]             wr_data,
  output logic                    master_en,
  output logic [NUM_CH-1:0]       pair_en,
  output logic [NUM_CH*CNT_W-1:0] low_thr,
  output logic [NUM_CH*CNT_W-1:0] high_thr,
  output logic [NUM_CH-1:0]       add_vld,
  output logic [NUM_CH-1:0]       load_vld,
  output logic [CNT_W-1:0]        wr_val
);
  fc_kind_e         kind;
  logic [CH_W-1:0]  wr_ch;
  logic             cfg_we;
  logic [CFG_W-1:0] cfg_d, cfg_q;
  logic             unused_bits;

  assign kind        = fc_kind_e'(wr_addr[1:0]);
  assign wr_ch       = wr_addr[CH_W+1:2];
  assign wr_val      = wr_data[CNT_W-1:0];
  assign unused_bits = ^wr_data[30:CNT_W];

  always_comb begin
    cfg_we = wr_en && (kind == KIND_CFG);
    cfg_d  = cfg_we ? wr_data[CFG_W-1:0] : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  assign master_en = cfg_q[0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             hit, low_we, high_we;
    logic [CNT_W-1:0] low_d, low_q, high_d, high_q;

    always_comb begin
      hit         = wr_en && (wr_ch == CH_W'(c));
      low_we      = hit && (kind == KIND_LOW);
      high_we     = hit && (kind == KIND_HIGH);
      add_vld[c]  = hit && (kind == KIND_ALLOC) && !wr_data[LOAD_FLAG_BIT];
      load_vld[c] = hit && (kind == KIND_ALLOC) &&  wr_data[LOAD_FLAG_BIT];
      low_d       = low_we  ? wr_val : low_q;
      high_d      = high_we ? wr_val : high_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        low_q  <= CNT_W'(LOW_RST);
        high_q <= CNT_W'(HIGH_RST);
      end else begin
        if (low_we)  low_q  <= low_d;
        if (high_we) high_q <= high_d;
      end
    end

    assign low_thr[c*CNT_W +: CNT_W]  = low_q;
    assign high_thr[c*CNT_W +: CNT_W] = high_q;
    assign pair_en[c] = cfg_q[pair_en_bit(c)];

    AST_ALLOC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(add_vld[c] && load_vld[c])) else $error("alloc add and load together"); // R3
  end
endmodule

// File: rtl/fc_buf_counter.sv
module fc_buf_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_vld,
  input  logic             load_vld,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             consume,
  output logic [CNT_W-1:0] count
);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [SUM_W-1:0] SAT_LIM = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] add_amt, count_d, count_q;
  logic [SUM_W-1:0] sum, net;
  logic             cnt_en;

  always_comb begin
    add_amt = add_vld ? wr_val : '0;
    sum     = {1'b0, count_q} + {1'b0, add_amt};
    net     = (consume && (sum != '0)) ? sum - SUM_W'(1) : sum;
    count_d = (net > SAT_LIM) ? CNT_MAX : net[CNT_W-1:0];
    if (load_vld) count_d = wr_val;
    cnt_en  = add_vld || load_vld || consume;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end

  assign count = count_q;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_vld |=> count == $past(wr_val)) else $error("load not taken"); // R3
  AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_vld && !add_vld && consume && count == '0) |=> count == '0) else $error("wrap below zero"); // R4
  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_vld && !add_vld && consume && count != '0) |=> count == $past(count) - CNT_W'(1)) else $error("bad decrement"); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_vld && !consume && add_vld && count == CNT_MAX) |=> count == CNT_MAX) else $error("wrap above max"); // R6
endmodule

// File: rtl/fc_hyst.sv
module fc_hyst #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] low_thr,
  input  logic [CNT_W-1:0] high_thr,
  output logic             req_st
);
  logic below, at_high, st_d, st_q;

  always_comb begin
    below   = count < low_thr;
    at_high = count >= high_thr;
    st_d    = st_q;
    if (below)        st_d = 1'b1;
    else if (at_high) st_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= 1'b0;
    else        st_q <= st_d;
  end

  assign req_st = st_q;

  AST_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (count < low_thr) |=> req_st) else $error("request did not set"); // R8
  AST_REQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= low_thr && count >= high_thr) |=> !req_st) else $error("request did not clear"); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= low_thr && count < high_thr) |=> $stable(req_st)) else $error("request moved in band"); // R9
endmodule

// File: rtl/rx_fc_tracker.sv
module rx_fc_tracker
  import rx_fc_pkg::*;
#(
  parameter  int NUM_CH     = 4,
  parameter  int CNT_W      = 8,
  parameter  int RING_DEPTH = 64,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W     = CH_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [31:0]             wr_data,
  input  logic [NUM_CH-1:0]       consume,
  output logic [NUM_CH-1:0]       fc_req,
  output logic [NUM_CH*CNT_W-1:0] buf_count
);
  localparam int CFG_W    = ((NUM_CH - 1) >> 1) + 2;
  localparam int LOW_RST  = RING_DEPTH / 3;
  localparam int HIGH_RST = (RING_DEPTH * 2) / 3;

  logic                    master_en;
  logic [NUM_CH-1:0]       pair_en, add_vld, load_vld;
  logic [NUM_CH*CNT_W-1:0] low_thr, high_thr;
  logic [CNT_W-1:0]        wr_val;

  fc_reg_decode #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .CH_W(CH_W), .CFG_W(CFG_W),
    .LOW_RST(LOW_RST), .HIGH_RST(HIGH_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .master_en(master_en), .pair_en(pair_en), .low_thr(low_thr), .high_thr(high_thr),
    .add_vld(add_vld), .load_vld(load_vld), .wr_val(wr_val)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [CNT_W-1:0] cnt;
    logic             req_st;

    fc_buf_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .add_vld(add_vld[c]), .load_vld(load_vld[c]),
      .wr_val(wr_val), .consume(consume[c]), .count(cnt)
    );

    fc_hyst #(.CNT_W(CNT_W)) u_hyst (
      .clk(clk), .rst_n(rst_n), .count(cnt),
      .low_thr(low_thr[c*CNT_W +: CNT_W]), .high_thr(high_thr[c*CNT_W +: CNT_W]),
      .req_st(req_st)
    );

    assign fc_req[c] = req_st && master_en && pair_en[c];
    assign buf_count[c*CNT_W +: CNT_W] = cnt;

    AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !(master_en && pair_en[c]) |-> !fc_req[c]) else $error("request leaked while disabled"); // R10
  end
endmodule

// File: tb/rx_fc_tracker_test.sv
module rx_fc_tracker_test;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int AW  = 4;
  localparam int MAXC = 255;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [31:0]       wr_data;
  logic [NCH-1:0]    consume;
  logic [NCH-1:0]    fc_req;
  logic [NCH*CW-1:0] buf_count;

  rx_fc_tracker #(.NUM_CH(NCH), .CNT_W(CW), .RING_DEPTH(64)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .consume(consume), .fc_req(fc_req), .buf_count(buf_count)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_cnt[NCH], m_low[NCH], m_high[NCH];
  bit m_st[NCH];
  int m_cfg;

  int    q_ch[$];
  int    q_cnt[$];
  bit    q_fc[$];
  string q_tag[$];

  function automatic bit exp_fc(input int c);
    return m_st[c] && m_cfg[0] && m_cfg[(c >> 1) + 1];
  endfunction

  task automatic push_all(input string tag);
    for (int c = 0; c < NCH; c++) begin
      q_ch.push_back(c); q_cnt.push_back(m_cnt[c]);
      q_fc.push_back(exp_fc(c)); q_tag.push_back(tag);
    end
  endtask

  task automatic step(input string tag);
    int kind, ch, val, n;
    @(posedge clk);
    kind = int'(wr_addr[1:0]);
    ch   = int'(wr_addr[3:2]);
    val  = int'(wr_data[CW-1:0]);
    for (int c = 0; c < NCH; c++) begin
      if (m_cnt[c] < m_low[c]) m_st[c] = 1'b1;
      else if (m_cnt[c] >= m_high[c]) m_st[c] = 1'b0;
    end
    for (int c = 0; c < NCH; c++) begin
      n = m_cnt[c];
      if (wr_en && kind == 3 && ch == c && !wr_data[31]) n = n + val;
      if (consume[c] && n > 0) n = n - 1;
      if (n > MAXC) n = MAXC;
      if (wr_en && kind == 3 && ch == c && wr_data[31]) n = val;
      m_cnt[c] = n;
    end
    if (wr_en && kind == 0) m_cfg = int'(wr_data[2:0]);
    if (wr_en && kind == 1) m_low[ch] = val;
    if (wr_en && kind == 2) m_high[ch] = val;
    push_all(tag);
    @(negedge clk);
    wr_en = 1'b0; consume = '0;
  endtask

  task automatic reg_wr(input int kind, input int ch, input logic [31:0] d, input string tag);
    wr_en = 1'b1; wr_addr = AW'((ch << 2) | kind); wr_data = d;
    step(tag);
  endtask

  task automatic eat(input logic [NCH-1:0] m, input string tag);
    consume = m;
    step(tag);
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      while (q_ch.size() > 0) begin
        int c, ec; bit ef; string t;
        c = q_ch.pop_front(); ec = q_cnt.pop_front();
        ef = q_fc.pop_front(); t = q_tag.pop_front();
        checks++;
        if (int'(buf_count[c*CW +: CW]) != ec) begin
          fails++;
          $display("FAIL %s ch%0d count actual=%0d expected=%0d", t, c, buf_count[c*CW +: CW], ec);
        end
        checks++;
        if (fc_req[c] !== ef) begin
          fails++;
          $display("FAIL %s ch%0d fc_req actual=%0b expected=%0b", t, c, fc_req[c], ef);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
    end
  end

  initial begin : driver
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; consume = '0;
    for (int c = 0; c < NCH; c++) begin
      m_cnt[c] = 0; m_st[c] = 0; m_low[c] = 21; m_high[c] = 42;
    end
    m_cfg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push_all("R1 reset state");
    step("R1 idle after reset");
    // enable global and both pair bits
    reg_wr(0, 0, 32'h7, "R10 enable all");
    reg_wr(3, 0, 32'd30, "R2 credit 30");
    step("R8 below low stays set");
    reg_wr(3, 0, 32'd12, "R2 credit to 42");
    step("R9 clears at high");
    for (int i = 0; i < 22; i++) eat(4'b0001, "R4 R9 consume through band");
    step("R8 set below low");
    wr_en = 1'b1; wr_addr = 4'h3; wr_data = 32'd3; consume = 4'b0001;
    step("R5 net add and consume");
    wr_en = 1'b1; wr_addr = 4'h3; wr_data = 32'h8000_0005; consume = 4'b0001;
    step("R3 R5 load beats consume");
    eat(4'b0010, "R4 floor at zero");
    reg_wr(3, 1, 32'd250, "R2 R11 credit ch1");
    reg_wr(3, 1, 32'd10, "R6 saturate");
    eat(4'b0010, "R6 decrement from max");
    reg_wr(1, 2, 32'd5, "R7 low ch2");
    reg_wr(2, 2, 32'd10, "R7 high ch2");
    reg_wr(3, 2, 32'd7, "R7 in band");
    step("R9 hold in band");
    reg_wr(3, 2, 32'd3, "R7 reach high");
    step("R9 clear ch2");
    for (int i = 0; i < 6; i++) eat(4'b0100, "R8 ch2 drop below low");
    step("R8 ch2 set");
    reg_wr(0, 3, 32'h3, "R10 R12 pair bit cleared");
    reg_wr(0, 0, 32'h5, "R10 pair bit swap");
    reg_wr(0, 0, 32'h6, "R10 master off");
    reg_wr(0, 0, 32'h7, "R10 re-enable");
    reg_wr(3, 3, 32'd44, "R12 R11 channel field");
    step("R9 ch3 clears");
    reg_wr(3, 3, 32'h8000_0000, "R3 load zero");
    step("R8 ch3 sets");
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_up();
  end
endmodule